// File: doc/BRIEF.md
# Posted Column Command Latency Tracker

This block listens to the command pins of a DDR2-style SDRAM bus from the device side. On every rising clock it decodes the pin pattern. When it sees a column command (a read or a write), it posts that command into an internal delay line. The command waits there for a programmable additive latency and then acts. A read opens a read-data window once the read latency (additive latency plus CAS latency) has elapsed. A write opens a write-capture window one clock earlier. A controller may issue a column command on the clock straight after a row activate, because the posting delay covers the row-to-column wait.

Each window carries one four-beat burst as two clock cycles of two beats each. For every cycle the block names the two columns being moved. The order wraps sequentially inside the aligned group of four columns that holds the start column. The block also guards the spacing between column commands. A column command that arrives too soon after the last accepted one is dropped and flagged for one cycle.

The two windows are output-only streams. `rd_valid` and `wr_valid` are valid strobes with no ready signal. SDRAM data timing is fixed by the latency settings, so a downstream consumer cannot apply back-pressure and must take every beat pair in the cycle it is presented. The latency inputs are plain static controls.

Top module: `ddr2_post_cas_tracker`

## Requirements
- R1: A column command is a rising edge with `sel_n`=0, `row_stb_n`=1 and `col_stb_n`=0; `wr_en_n`=1 makes it a read and `wr_en_n`=0 a write. Every other pattern, including a deselected bus (`sel_n`=1) and an activate (`row_stb_n`=0, `col_stb_n`=1), opens no window.
- R2: `cfg_al` and `cfg_cl` are captured only on edges where no command is pending and no window is open. Changes made while busy do not affect commands already in flight or commands accepted before the block next goes idle. `cfg_al` above 4 counts as 4; `cfg_cl` counts as 3 when below 3 and as 5 when above 5.
- R3: A read accepted at edge E drives `rd_valid` high for the two cycles that follow edges E+AL+CL and E+AL+CL+1.
- R4: A write accepted at edge E drives `wr_valid` high for the two cycles that follow edges E+AL+CL-1 and E+AL+CL.
- R5: The start column's bits [1:0] are the offset s, and bits [COL_W-1:2] are kept in every beat. The first window cycle presents offsets s and s+1 on `*_col_a` and `*_col_b`. The second presents s+2 and s+3. All offsets are taken modulo 4.
- R6: Column commands accepted two clocks apart produce back-to-back windows with no gap, each carrying its own columns; a read and a write two clocks apart both appear on their own outputs.
- R7: A column command presented one clock after the last accepted column command is dropped and makes `spacing_err` high for exactly the cycle after that edge. Spacing is always measured from the last accepted command, not from a dropped one.
- R8: A column command on the edge immediately after an activate is accepted normally.
- R9: Synchronous active-high `rst` drops every pending command and open window; all outputs are low while it is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Device select, active low |
| row_stb_n | input | 1 | Row strobe, active low |
| col_stb_n | input | 1 | Column strobe, active low |
| wr_en_n | input | 1 | Write enable, active low |
| col_addr | input | COL_W | Column address given with a column command |
| cfg_al | input | CFG_W | Additive latency setting |
| cfg_cl | input | CFG_W | CAS latency setting |
| rd_valid | output | 1 | Read-data window strobe |
| rd_col_a | output | COL_W | Column of the first read beat this cycle |
| rd_col_b | output | COL_W | Column of the second read beat this cycle |
| wr_valid | output | 1 | Write-capture window strobe |
| wr_col_a | output | COL_W | Column of the first write beat this cycle |
| wr_col_b | output | COL_W | Column of the second write beat this cycle |
| spacing_err | output | 1 | One-cycle pulse for a dropped, too-close column command |

## Verification
Every additive latency from 0 to 4 is combined with every CAS latency from 3 to 5, and each pairing is tried with all four start offsets for both reads and writes. This sweep separates read from write latency, separates an off-by-one in either, and exposes any wrap-order error. Column commands are then sent at gaps of one, two and three clocks. These show whether windows stay seamless, whether too-close commands are dropped, and whether spacing is counted from the accepted command. Further patterns cover latency changes made while commands are in flight, out-of-range settings, decoys that are not column commands, an activate directly followed by a read, and a reset taken mid-flight.

// File: rtl/ddr2_post_pkg.sv
package ddr2_post_pkg;

  typedef enum logic [1:0] {
    BUS_IDLE,
    BUS_OPEN_ROW,
    BUS_COL_RD,
    BUS_COL_WR
  } bus_op_e;

  function automatic bus_op_e classify_pins(input logic sel_n, input logic row_n,
                                            input logic col_n, input logic we_n);
    bus_op_e op;
    op = BUS_IDLE;
    if (!sel_n) begin
      if (!row_n && col_n) op = BUS_OPEN_ROW;
      else if (row_n && !col_n) op = we_n ? BUS_COL_RD : BUS_COL_WR;
    end
    return op;
  endfunction

endpackage

// File: rtl/cas_cmd_gate.sv
module cas_cmd_gate
  import ddr2_post_pkg::*;
#(
  parameter int COL_W   = 10,
  parameter int MIN_GAP = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_n,
  input  logic             row_stb_n,
  input  logic             col_stb_n,
  input  logic             wr_en_n,
  input  logic [COL_W-1:0] col_addr,
  output logic             acc_valid,
  output logic             acc_wr,
  output logic [COL_W-1:0] acc_col,
  output logic             spacing_err
);
  localparam int GAP_W = (MIN_GAP > 2) ? $clog2(MIN_GAP) : 1;
  localparam logic [GAP_W-1:0] GAP_SAT = GAP_W'(MIN_GAP - 1);

  bus_op_e          op;
  logic             is_col;
  logic             far_enough;
  logic [GAP_W-1:0] since_q;

  always_comb begin
    op         = classify_pins(sel_n, row_stb_n, col_stb_n, wr_en_n);
    is_col     = (op == BUS_COL_RD) || (op == BUS_COL_WR);
    far_enough = (since_q == GAP_SAT);
    acc_valid  = is_col && far_enough;
    acc_wr     = (op == BUS_COL_WR);
    acc_col    = col_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      since_q     <= GAP_SAT;
      spacing_err <= 1'b0;
    end else begin
      spacing_err <= is_col && !far_enough;
      if (acc_valid) since_q <= '0;
      else if (since_q != GAP_SAT) since_q <= since_q + 1'b1;
    end
  end

endmodule

// File: rtl/cas_post_line.sv
module cas_post_line #(
  parameter int COL_W = 10,
  parameter int DEPTH = 10,
  parameter int TAP_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_wr,
  input  logic [COL_W-1:0] in_col,
  input  logic [TAP_W-1:0] tap [2],
  output logic             hit [2],
  output logic [COL_W-1:0] hit_col [2],
  output logic             busy
);
  logic [DEPTH-1:0] stg_v;
  logic [DEPTH-1:0] stg_w;
  logic [COL_W-1:0] stg_c [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_v <= '0;
      stg_w <= '0;
    end else begin
      stg_v <= {stg_v[DEPTH-2:0], in_valid};
      stg_w <= {stg_w[DEPTH-2:0], in_wr};
    end
  end

  always_ff @(posedge clk) stg_c[0] <= in_col;

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk) stg_c[i] <= stg_c[i-1];
  end

  // lane 0 picks reads, lane 1 picks writes
  for (genvar l = 0; l < 2; l++) begin : g_lane
    always_comb begin
      hit[l]     = stg_v[tap[l]] && (stg_w[tap[l]] == (l == 1));
      hit_col[l] = stg_c[tap[l]];
    end
  end

  assign busy = |stg_v;

endmodule

// File: rtl/cas_burst_win.sv
module cas_burst_win #(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  output logic             valid,
  output logic [COL_W-1:0] col_a,
  output logic [COL_W-1:0] col_b
);
  localparam int GRP_W = COL_W - 2;

  logic             active_q;
  logic             second_q;
  logic [GRP_W-1:0] group_q;
  logic [1:0]       offs_q;
  logic [1:0]       lane_a;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      second_q <= 1'b0;
    end else if (start) begin
      active_q <= 1'b1;
      second_q <= 1'b0;
    end else if (active_q && !second_q) begin
      second_q <= 1'b1;
    end else begin
      active_q <= 1'b0;
      second_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (start) begin
      group_q <= start_col[COL_W-1:2];
      offs_q  <= start_col[1:0];
    end
  end

  always_comb begin
    lane_a = offs_q + (second_q ? 2'd2 : 2'd0);
    valid  = active_q;
    col_a  = {group_q, lane_a};
    col_b  = {group_q, lane_a + 2'd1};
  end

endmodule

// File: rtl/ddr2_post_cas_tracker.sv
module ddr2_post_cas_tracker #(
  parameter int COL_W   = 10,
  parameter int CFG_W   = 3,
  parameter int DEPTH   = 10,
  parameter int MIN_GAP = 2,
  parameter int AL_MAX  = 4,
  parameter int CL_MIN  = 3,
  parameter int CL_MAX  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_n,
  input  logic             row_stb_n,
  input  logic             col_stb_n,
  input  logic             wr_en_n,
  input  logic [COL_W-1:0] col_addr,
  input  logic [CFG_W-1:0] cfg_al,
  input  logic [CFG_W-1:0] cfg_cl,
  output logic             rd_valid,
  output logic [COL_W-1:0] rd_col_a,
  output logic [COL_W-1:0] rd_col_b,
  output logic             wr_valid,
  output logic [COL_W-1:0] wr_col_a,
  output logic [COL_W-1:0] wr_col_b,
  output logic             spacing_err
);
  localparam int RL_MAX = AL_MAX + CL_MAX;
  localparam int LAT_W  = $clog2(RL_MAX + 1);
  localparam int TAP_W  = $clog2(DEPTH);

  logic             acc_valid;
  logic             acc_wr;
  logic [COL_W-1:0] acc_col;

  cas_cmd_gate #(.COL_W(COL_W), .MIN_GAP(MIN_GAP)) u_gate (
    .clk        (clk),
    .rst        (rst),
    .sel_n      (sel_n),
    .row_stb_n  (row_stb_n),
    .col_stb_n  (col_stb_n),
    .wr_en_n    (wr_en_n),
    .col_addr   (col_addr),
    .acc_valid  (acc_valid),
    .acc_wr     (acc_wr),
    .acc_col    (acc_col),
    .spacing_err(spacing_err)
  );

  // latency latch, refreshed only while nothing is in flight
  logic [LAT_W-1:0] al_eff, cl_eff, rl_q;
  logic             line_busy;
  logic             idle;

  always_comb begin
    al_eff = (cfg_al > CFG_W'(AL_MAX)) ? LAT_W'(AL_MAX) : LAT_W'(cfg_al);
    if (cfg_cl < CFG_W'(CL_MIN))      cl_eff = LAT_W'(CL_MIN);
    else if (cfg_cl > CFG_W'(CL_MAX)) cl_eff = LAT_W'(CL_MAX);
    else                              cl_eff = LAT_W'(cfg_cl);
    idle = !line_busy && !rd_valid && !wr_valid;
  end

  always_ff @(posedge clk) begin
    if (rst)       rl_q <= LAT_W'(CL_MIN);
    else if (idle) rl_q <= al_eff + cl_eff;
  end

  logic [TAP_W-1:0] tap [2];
  logic             hit [2];
  logic [COL_W-1:0] hit_col [2];

  always_comb begin
    tap[0] = TAP_W'(rl_q - LAT_W'(1));
    tap[1] = TAP_W'(rl_q - LAT_W'(2));
  end

  cas_post_line #(.COL_W(COL_W), .DEPTH(DEPTH), .TAP_W(TAP_W)) u_line (
    .clk     (clk),
    .rst     (rst),
    .in_valid(acc_valid),
    .in_wr   (acc_wr),
    .in_col  (acc_col),
    .tap     (tap),
    .hit     (hit),
    .hit_col (hit_col),
    .busy    (line_busy)
  );

  logic             win_v [2];
  logic [COL_W-1:0] win_a [2];
  logic [COL_W-1:0] win_b [2];

  for (genvar l = 0; l < 2; l++) begin : g_win
    cas_burst_win #(.COL_W(COL_W)) u_win (
      .clk      (clk),
      .rst      (rst),
      .start    (hit[l]),
      .start_col(hit_col[l]),
      .valid    (win_v[l]),
      .col_a    (win_a[l]),
      .col_b    (win_b[l])
    );
  end

  assign rd_valid = win_v[0];
  assign rd_col_a = win_a[0];
  assign rd_col_b = win_b[0];
  assign wr_valid = win_v[1];
  assign wr_col_a = win_a[1];
  assign wr_col_b = win_b[1];

endmodule

// File: rtl/cas_tracker_checker.sv
module cas_tracker_checker #(
  parameter int COL_W = 10,
  parameter int LAT_W = 4,
  parameter int RL_LO = 3,
  parameter int RL_HI = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             sel_n,
  input logic             row_stb_n,
  input logic             col_stb_n,
  input logic             rd_valid,
  input logic [COL_W-1:0] rd_col_a,
  input logic             wr_valid,
  input logic [COL_W-1:0] wr_col_a,
  input logic             spacing_err,
  input logic [LAT_W-1:0] rl_q,
  input logic             line_busy
);

  assert_err_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    spacing_err |=> !spacing_err);

  assert_err_cause_R7: assert property (@(posedge clk) disable iff (rst)
    spacing_err |-> $past(!sel_n && row_stb_n && !col_stb_n));

  assert_rd_pair_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_valid) |=> rd_valid
      && (rd_col_a[1:0] == $past(rd_col_a[1:0]) + 2'd2)
      && (rd_col_a[COL_W-1:2] == $past(rd_col_a[COL_W-1:2])));

  assert_wr_pair_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_valid) |=> wr_valid
      && (wr_col_a[1:0] == $past(wr_col_a[1:0]) + 2'd2)
      && (wr_col_a[COL_W-1:2] == $past(wr_col_a[COL_W-1:2])));

  assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (rst)
    $past(line_busy || rd_valid || wr_valid) |-> $stable(rl_q));

  assert_rl_range_R3: assert property (@(posedge clk) disable iff (rst)
    (rl_q >= LAT_W'(RL_LO)) && (rl_q <= LAT_W'(RL_HI)));

endmodule

bind ddr2_post_cas_tracker cas_tracker_checker #(
  .COL_W(COL_W),
  .LAT_W(LAT_W),
  .RL_LO(CL_MIN),
  .RL_HI(AL_MAX + CL_MAX)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sel_n      (sel_n),
  .row_stb_n  (row_stb_n),
  .col_stb_n  (col_stb_n),
  .rd_valid   (rd_valid),
  .rd_col_a   (rd_col_a),
  .wr_valid   (wr_valid),
  .wr_col_a   (wr_col_a),
  .spacing_err(spacing_err),
  .rl_q       (rl_q),
  .line_busy  (line_busy)
);

// File: tb/ddr2_post_cas_tracker_tb.sv
module ddr2_post_cas_tracker_tb;
  localparam int CW = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sel_n = 1'b1, row_stb_n = 1'b1, col_stb_n = 1'b1, wr_en_n = 1'b1;
  logic [CW-1:0] col_addr = '0;
  logic [2:0]    cfg_al = 3'd0, cfg_cl = 3'd3;
  logic          rd_valid, wr_valid, spacing_err;
  logic [CW-1:0] rd_col_a, rd_col_b, wr_col_a, wr_col_b;

  ddr2_post_cas_tracker u_dut (
    .clk(clk), .rst(rst), .sel_n(sel_n), .row_stb_n(row_stb_n),
    .col_stb_n(col_stb_n), .wr_en_n(wr_en_n), .col_addr(col_addr),
    .cfg_al(cfg_al), .cfg_cl(cfg_cl),
    .rd_valid(rd_valid), .rd_col_a(rd_col_a), .rd_col_b(rd_col_b),
    .wr_valid(wr_valid), .wr_col_a(wr_col_a), .wr_col_b(wr_col_b),
    .spacing_err(spacing_err)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  int m_al = 0, m_cl = 3;
  int last_acc = -100;
  bit done = 0;

  logic          ex_v [2][64];
  logic [CW-1:0] ex_a [2][64];
  logic [CW-1:0] ex_b [2][64];
  logic          ex_e [64];

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: got %0h expected %0h", tag, cyc, got, exp);
    end
  endtask

  task automatic clear_ring();
    for (int i = 0; i < 64; i++) begin
      ex_v[0][i] = 0; ex_v[1][i] = 0; ex_e[i] = 0;
      ex_a[0][i] = '0; ex_a[1][i] = '0; ex_b[0][i] = '0; ex_b[1][i] = '0;
    end
  endtask

  // per-cycle scoreboard: R3 read window, R4 write window, R5 columns, R7 pulse
  always @(negedge clk) begin
    if (!rst && !done) begin
      int k;
      k = cyc % 64;
      chk("R3 rd_valid", 32'(rd_valid), 32'(ex_v[0][k]));
      chk("R4 wr_valid", 32'(wr_valid), 32'(ex_v[1][k]));
      chk("R7 spacing_err", 32'(spacing_err), 32'(ex_e[k]));
      if (ex_v[0][k]) begin
        chk("R5 rd_col_a", 32'(rd_col_a), 32'(ex_a[0][k]));
        chk("R5 rd_col_b", 32'(rd_col_b), 32'(ex_b[0][k]));
      end
      if (ex_v[1][k]) begin
        chk("R5 wr_col_a", 32'(wr_col_a), 32'(ex_a[1][k]));
        chk("R5 wr_col_b", 32'(wr_col_b), 32'(ex_b[1][k]));
      end
      ex_v[0][k] = 0; ex_v[1][k] = 0; ex_e[k] = 0;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic nop_pins();
    sel_n = 1'b1; row_stb_n = 1'b1; col_stb_n = 1'b1; wr_en_n = 1'b1;
  endtask

  task automatic expect_win(input int lane, input int t, input logic [CW-1:0] col);
    logic [1:0] s;
    s = col[1:0];
    ex_v[lane][t%64] = 1;
    ex_a[lane][t%64] = {col[CW-1:2], s};
    ex_b[lane][t%64] = {col[CW-1:2], 2'(s + 2'd1)};
    ex_v[lane][(t+1)%64] = 1;
    ex_a[lane][(t+1)%64] = {col[CW-1:2], 2'(s + 2'd2)};
    ex_b[lane][(t+1)%64] = {col[CW-1:2], 2'(s + 2'd3)};
  endtask

  // R1 column command, R3/R4 latency model, R7 spacing model
  task automatic issue(input bit is_wr, input logic [CW-1:0] col);
    int e;
    e = cyc + 1;
    sel_n = 1'b0; row_stb_n = 1'b1; col_stb_n = 1'b0; wr_en_n = !is_wr; col_addr = col;
    if (e - last_acc < 2) ex_e[e%64] = 1;
    else begin
      last_acc = e;
      expect_win(is_wr ? 1 : 0, e + m_al + m_cl - (is_wr ? 1 : 0), col);
    end
    @(negedge clk);
    nop_pins();
  endtask

  task automatic raw(input logic s, input logic r, input logic c, input logic w);
    sel_n = s; row_stb_n = r; col_stb_n = c; wr_en_n = w; col_addr = 10'h3FF;
    @(negedge clk);
    nop_pins();
  endtask

  task automatic set_cfg(input int al, input int cl);
    cfg_al = 3'(al); cfg_cl = 3'(cl);
    m_al = (al > 4) ? 4 : al;
    m_cl = (cl < 3) ? 3 : ((cl > 5) ? 5 : cl);
    idle(3);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    clear_ring();
    last_acc = -100;
    idle(2);
    chk("R9 outputs low in reset", 32'({rd_valid, wr_valid, spacing_err}), 32'd0);
    rst = 1'b0;
    idle(1);
  endtask

  initial begin
    clear_ring();
    @(negedge clk);
    do_reset();

    // R3 R4 R5: sweep every latency pair and start offset
    for (int al = 0; al <= 4; al++) begin
      for (int cl = 3; cl <= 5; cl++) begin
        set_cfg(al, cl);
        for (int s = 0; s < 4; s++) begin
          issue(1'b0, CW'((al * 48 + cl * 12 + s * 4) % 256 * 4 + s));
          idle(2);
          issue(1'b1, CW'(((al + cl + s) * 37) % 256 * 4 + (3 - s)));
          idle(13);
        end
      end
    end

    // R6: seamless back-to-back reads, then read and write two apart
    set_cfg(2, 3);
    issue(1'b0, 10'h011); idle(1);
    issue(1'b0, 10'h126); idle(1);
    issue(1'b0, 10'h2F3); idle(1);
    issue(1'b1, 10'h0A2); idle(14);
    issue(1'b1, 10'h041); idle(1);
    issue(1'b1, 10'h35C); idle(1);
    issue(1'b0, 10'h1E7); idle(14);

    // R7: too-close commands are dropped; gap measured from the accepted one
    issue(1'b0, 10'h100);
    issue(1'b0, 10'h204);
    issue(1'b1, 10'h309);
    idle(1);
    issue(1'b1, 10'h00D);
    idle(2);
    issue(1'b0, 10'h2AB);
    idle(14);

    // R1: decoys open nothing (deselected, activate, row+col both low, write pins deselected)
    raw(1'b1, 1'b1, 1'b0, 1'b1);
    idle(1);
    raw(1'b0, 1'b0, 1'b1, 1'b1);
    idle(1);
    raw(1'b0, 1'b0, 1'b0, 1'b0);
    idle(1);
    raw(1'b1, 1'b1, 1'b0, 1'b0);
    idle(14);

    // R8: activate immediately followed by a read
    set_cfg(3, 4);
    raw(1'b0, 1'b0, 1'b1, 1'b1);
    issue(1'b0, 10'h1B6);
    idle(14);

    // R2: a latency change while busy is held off until idle
    set_cfg(1, 3);
    issue(1'b0, 10'h0C5);
    cfg_al = 3'd4; cfg_cl = 3'd5;
    issue(1'b0, 10'h0D2);
    idle(16);
    set_cfg(4, 5);
    issue(1'b0, 10'h3E9); idle(1);
    issue(1'b1, 10'h3EA);
    idle(16);

    // R2: out-of-range settings are clamped
    set_cfg(7, 7);
    issue(1'b0, 10'h155); idle(1);
    issue(1'b1, 10'h156);
    idle(16);
    set_cfg(0, 1);
    issue(1'b0, 10'h08B); idle(1);
    issue(1'b1, 10'h08C);
    idle(14);

    // R9: reset drops a pending read and an open window
    set_cfg(2, 5);
    issue(1'b0, 10'h222); idle(1);
    issue(1'b1, 10'h333);
    idle(4);
    do_reset();
    idle(16);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule